// File: doc/BRIEF.md
# Flash Toggle-Status Poller

This block is the host-side sequencer that waits for a flash device to finish a program or erase. It does this by reading the device status byte over and over. It works out completion from the toggle bit (bit 6). It watches the exceeded-limit bit (bit 5) and a poll budget, and after a failure it writes a reset command to the device. When completion is seen, it reads once more and returns that byte as the final data. In a second mode it adds one sector-erase command to an erase that is already set up. It reads the erase-window bit (bit 3) before the command and again after it.

A host pulses `start_i` with `mode_i` and `max_polls_i`. It then waits for the one-cycle `done_o` pulse and reads the code on `result_o`. Each flash access is a strobe (`rd_req_o` or `wr_req_o`) that stays high until `bus_ack_i`. The parameter `GAP_CYCLES` sets a minimum number of idle cycles between strobes. This stands in for the device's output-enable access time. Addressing and data buffering are outside the block.

Top module: `flash_toggle_poller`

## Requirements
- R1: During reset and after it, both strobes, `busy_o` and `done_o` are low.
- R2: Wait mode (`mode_i`=0) starts with one reference read, then makes loop reads. The first loop read whose bit 6 equals that of the previous read is followed by exactly one more read. `done_o` then reports code 0 (ok), with `data_o` holding that last read's byte.
- R3: Between the end of one strobe (acknowledged) and the start of the next, at least `GAP_CYCLES` idle clock cycles pass.
- R4: Suppose a loop read toggles with bit 5 = 1. If the next loop read toggles again, the block writes `RESET_CMD` (0xF0) once and reports code 1 (limit exceeded).
- R5: If the loop read after a toggling bit-5 read does not toggle, the block makes the final read and reports code 0 with that byte, without writing.
- R6: At most `max_polls_i` (at least 1) loop reads are made. A toggling loop read that uses up the budget leads to one `RESET_CMD` write and code 2 (timeout). This holds even if that read has bit 5 = 1.
- R7: In sector mode (`mode_i`=1) the block first reads status. If bit 3 is 1, it writes nothing and reports code 3 (refused).
- R8: In sector mode with bit 3 = 0 on the first read, the block writes `ERASE_CMD` (0x30) once and then reads again. It reports code 4 (possibly not accepted) if bit 3 is then 1, and otherwise code 0 with that byte in `data_o`.
- R9: `start_i` while `busy_o` is high has no effect on the running operation.
- R10: A strobe stays high until acknowledged, read and write strobes are never high together, and `done_o` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| mode_i | input | 1 | 0: wait for completion, 1: add sector-erase command |
| max_polls_i | input | CNT_W | Loop-read budget in wait mode, held stable while busy |
| rd_req_o | output | 1 | Status read strobe |
| wr_req_o | output | 1 | Command write strobe |
| wr_data_o | output | DW | Command byte for the write strobe |
| bus_ack_i | input | 1 | Flash access completed |
| rd_data_i | input | DW | Status or data byte, valid with `bus_ack_i` on a read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | Outcome code (0 ok, 1 limit, 2 timeout, 3 refused, 4 unconfirmed) |
| data_o | output | DW | Final byte of a successful operation |

## Verification
A single loop read can do two things at once: it can carry bit 5 = 1, which would arm the one extra toggle check, and it can also use up the last poll of the budget. The bench builds this case on purpose. It sets `max_polls_i` to 2 and returns a script whose second loop read toggles with bit 5 set. It then expects a timeout code after exactly three reads and one reset write. Random scripts with short budgets and bit 5 set on about one read in eight produce the same overlap again, as well as the overlap of an armed limit check with the last allowed read. A bench model derived from the requirements judges every outcome.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

   typedef enum logic [2:0] {
      RES_OK          = 3'd0,
      RES_LIMIT       = 3'd1,
      RES_TIMEOUT     = 3'd2,
      RES_REFUSED     = 3'd3,
      RES_UNCONFIRMED = 3'd4
   } poll_result_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FIRST,
      ST_LOOP,
      ST_FINAL,
      ST_PRE,
      ST_CMD,
      ST_POST,
      ST_RST,
      ST_REPORT
   } poll_state_e;

endpackage

// File: rtl/poll_gap_timer.sv
module poll_gap_timer #(
   parameter int GAP_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic open_o
);

   generate
      if (GAP_CYCLES == 0) begin : g_no_gap
         logic unused_gap;
         assign unused_gap = ^{clk, rst_n, kick_i};
         assign open_o     = 1'b1;
      end else begin : g_gap
         localparam int GW = $clog2(GAP_CYCLES + 1);
         logic [GW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (kick_i) begin
               cnt_q <= GW'(GAP_CYCLES);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign open_o = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/poll_bus_port.sv
module poll_bus_port #(
   parameter int DW         = 8,
   parameter int GAP_CYCLES = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_i,
   input  logic          is_wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          ready_o,
   output logic          resp_o,
   output logic [DW-1:0] rdata_o,
   output logic          rd_req_o,
   output logic          wr_req_o,
   output logic [DW-1:0] wr_data_o,
   input  logic          bus_ack_i,
   input  logic [DW-1:0] rd_data_i
);

   localparam int IW = $clog2(GAP_CYCLES + 2);

   logic active;
   logic finish;
   logic gap_open;

   assign active = rd_req_o | wr_req_o;
   assign finish = active & bus_ack_i;

   poll_gap_timer #(
      .GAP_CYCLES (GAP_CYCLES)
   ) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick_i (finish),
      .open_o (gap_open)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req_o  <= 1'b0;
         wr_req_o  <= 1'b0;
         wr_data_o <= '0;
         resp_o    <= 1'b0;
         rdata_o   <= '0;
      end else begin
         resp_o <= 1'b0;
         if (finish) begin
            rd_req_o <= 1'b0;
            wr_req_o <= 1'b0;
            resp_o   <= 1'b1;
            if (rd_req_o) begin
               rdata_o <= rd_data_i;
            end
         end else if (issue_i && !active) begin
            rd_req_o <= !is_wr_i;
            wr_req_o <= is_wr_i;
            if (is_wr_i) begin
               wr_data_o <= wdata_i;
            end
         end
      end
   end

   assign ready_o = !active && gap_open;

   // idle-cycle monitor for the strobe spacing rule
   logic [IW-1:0] idle_q;
   logic          prev_active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q        <= IW'(GAP_CYCLES);
         prev_active_q <= 1'b0;
      end else begin
         prev_active_q <= active;
         if (active) begin
            idle_q <= '0;
         end else if (idle_q < IW'(GAP_CYCLES)) begin
            idle_q <= idle_q + 1'b1;
         end
      end
   end

   assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !prev_active_q) |-> (idle_q >= IW'(GAP_CYCLES)));

   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !bus_ack_i) |=> rd_req_o);

   assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !bus_ack_i) |=> (wr_req_o && $stable(wr_data_o)));

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_o && wr_req_o));

endmodule

// File: rtl/poll_seq.sv
module poll_seq
   import flash_poll_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          CNT_W     = 8,
   parameter int          TOG_BIT   = 6,
   parameter int          LIM_BIT   = 5,
   parameter int          WIN_BIT   = 3,
   parameter logic [DW-1:0] RESET_CMD = 8'hF0,
   parameter logic [DW-1:0] ERASE_CMD = 8'h30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode_i,
   input  logic [CNT_W-1:0] max_polls_i,
   input  logic             port_ready_i,
   input  logic             port_resp_i,
   input  logic [DW-1:0]    port_rdata_i,
   output logic             issue_o,
   output logic             is_wr_o,
   output logic [DW-1:0]    wdata_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [2:0]       result_o,
   output logic [DW-1:0]    data_o
);

   poll_state_e    state_q;
   poll_result_e   res_q;
   logic           pend_q;
   logic           prev_tog_q;
   logic           lim_q;
   logic [CNT_W-1:0] polls_q;
   logic [CNT_W-1:0] polls_nx;
   logic [DW-1:0]  data_q;
   logic           done_q;
   logic           wants_bus;
   logic           toggled;

   assign polls_nx = polls_q + 1'b1;
   assign toggled  = port_rdata_i[TOG_BIT] != prev_tog_q;

   always_comb begin
      wants_bus = 1'b0;
      case (state_q)
         ST_FIRST, ST_LOOP, ST_FINAL, ST_PRE,
         ST_CMD, ST_POST, ST_RST: wants_bus = 1'b1;
         default:                 wants_bus = 1'b0;
      endcase
   end

   assign issue_o = wants_bus && !pend_q && port_ready_i;
   assign is_wr_o = (state_q == ST_CMD) || (state_q == ST_RST);
   assign wdata_o = (state_q == ST_CMD) ? ERASE_CMD : RESET_CMD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         res_q      <= RES_OK;
         pend_q     <= 1'b0;
         prev_tog_q <= 1'b0;
         lim_q      <= 1'b0;
         polls_q    <= '0;
         data_q     <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (issue_o) begin
            pend_q <= 1'b1;
         end else if (port_resp_i) begin
            pend_q <= 1'b0;
         end
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  polls_q <= '0;
                  lim_q   <= 1'b0;
                  state_q <= mode_i ? ST_PRE : ST_FIRST;
               end
            end
            ST_FIRST: begin
               if (port_resp_i) begin
                  prev_tog_q <= port_rdata_i[TOG_BIT];
                  state_q    <= ST_LOOP;
               end
            end
            ST_LOOP: begin
               if (port_resp_i) begin
                  polls_q <= polls_nx;
                  if (!toggled) begin
                     state_q <= ST_FINAL;
                  end else begin
                     prev_tog_q <= port_rdata_i[TOG_BIT];
                     if (lim_q) begin
                        res_q   <= RES_LIMIT;
                        state_q <= ST_RST;
                     end else if (polls_nx >= max_polls_i) begin
                        res_q   <= RES_TIMEOUT;
                        state_q <= ST_RST;
                     end else if (port_rdata_i[LIM_BIT]) begin
                        lim_q <= 1'b1;
                     end
                  end
               end
            end
            ST_FINAL: begin
               if (port_resp_i) begin
                  data_q  <= port_rdata_i;
                  res_q   <= RES_OK;
                  state_q <= ST_REPORT;
               end
            end
            ST_PRE: begin
               if (port_resp_i) begin
                  if (port_rdata_i[WIN_BIT]) begin
                     res_q   <= RES_REFUSED;
                     state_q <= ST_REPORT;
                  end else begin
                     state_q <= ST_CMD;
                  end
               end
            end
            ST_CMD: begin
               if (port_resp_i) begin
                  state_q <= ST_POST;
               end
            end
            ST_POST: begin
               if (port_resp_i) begin
                  data_q  <= port_rdata_i;
                  res_q   <= port_rdata_i[WIN_BIT] ? RES_UNCONFIRMED : RES_OK;
                  state_q <= ST_REPORT;
               end
            end
            ST_RST: begin
               if (port_resp_i) begin
                  state_q <= ST_REPORT;
               end
            end
            ST_REPORT: begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign result_o = res_q;
   assign data_o   = data_q;

   assert_poll_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && max_polls_i != '0) |-> (polls_q <= max_polls_i));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_no_issue_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !issue_o);

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
   parameter int            DW         = 8,
   parameter int            CNT_W      = 8,
   parameter int            GAP_CYCLES = 3,
   parameter int            TOG_BIT    = 6,
   parameter int            LIM_BIT    = 5,
   parameter int            WIN_BIT    = 3,
   parameter logic [DW-1:0] RESET_CMD  = 8'hF0,
   parameter logic [DW-1:0] ERASE_CMD  = 8'h30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode_i,
   input  logic [CNT_W-1:0] max_polls_i,
   output logic             rd_req_o,
   output logic             wr_req_o,
   output logic [DW-1:0]    wr_data_o,
   input  logic             bus_ack_i,
   input  logic [DW-1:0]    rd_data_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [2:0]       result_o,
   output logic [DW-1:0]    data_o
);

   generate
      if (TOG_BIT >= DW || LIM_BIT >= DW || WIN_BIT >= DW) begin : g_bad_bits
         $error("status bit position outside the data width");
      end
      if (CNT_W < 1 || GAP_CYCLES < 0) begin : g_bad_size
         $error("poll counter width or gap length out of range");
      end
      if (RESET_CMD == ERASE_CMD) begin : g_bad_cmd
         $error("reset and erase command bytes must differ");
      end
   endgenerate

   logic          issue;
   logic          is_wr;
   logic [DW-1:0] wdata;
   logic          port_ready;
   logic          port_resp;
   logic [DW-1:0] port_rdata;

   poll_seq #(
      .DW        (DW),
      .CNT_W     (CNT_W),
      .TOG_BIT   (TOG_BIT),
      .LIM_BIT   (LIM_BIT),
      .WIN_BIT   (WIN_BIT),
      .RESET_CMD (RESET_CMD),
      .ERASE_CMD (ERASE_CMD)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .mode_i       (mode_i),
      .max_polls_i  (max_polls_i),
      .port_ready_i (port_ready),
      .port_resp_i  (port_resp),
      .port_rdata_i (port_rdata),
      .issue_o      (issue),
      .is_wr_o      (is_wr),
      .wdata_o      (wdata),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .result_o     (result_o),
      .data_o       (data_o)
   );

   poll_bus_port #(
      .DW         (DW),
      .GAP_CYCLES (GAP_CYCLES)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_i   (issue),
      .is_wr_i   (is_wr),
      .wdata_i   (wdata),
      .ready_o   (port_ready),
      .resp_o    (port_resp),
      .rdata_o   (port_rdata),
      .rd_req_o  (rd_req_o),
      .wr_req_o  (wr_req_o),
      .wr_data_o (wr_data_o),
      .bus_ack_i (bus_ack_i),
      .rd_data_i (rd_data_i)
   );

   // window bit seen on the most recent completed read
   logic last_win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_win_q <= 1'b0;
      end else if (rd_req_o && bus_ack_i) begin
         last_win_q <= rd_data_i[WIN_BIT];
      end
   end

   assert_erase_needs_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && wr_data_o == ERASE_CMD) |-> !last_win_q);

   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o)) |-> !(rd_req_o || wr_req_o));

endmodule

// File: tb/flash_toggle_poller_bench.sv
module flash_toggle_poller_bench;

   localparam int GAP = 3;

   logic       clk;
   logic       rst_n;
   logic       start;
   logic       mode;
   logic [7:0] max_polls;
   logic       rd_req;
   logic       wr_req;
   logic [7:0] wr_data;
   logic       ack;
   logic [7:0] rdat;
   logic       busy;
   logic       done;
   logic [2:0] result;
   logic [7:0] data;

   int checks = 0;
   int fails  = 0;
   int rd_idx = 0;
   int wr_cnt = 0;
   logic [7:0] wr_last = 8'h00;
   int gap_bad = 0;
   int both_bad = 0;
   int done_wide = 0;

   logic [7:0] scr [0:31];

   flash_toggle_poller #(.GAP_CYCLES(GAP)) u_flash_toggle_poller (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .mode_i      (mode),
      .max_polls_i (max_polls),
      .rd_req_o    (rd_req),
      .wr_req_o    (wr_req),
      .wr_data_o   (wr_data),
      .bus_ack_i   (ack),
      .rd_data_i   (rdat),
      .busy_o      (busy),
      .done_o      (done),
      .result_o    (result),
      .data_o      (data)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // expected outcome derived from the requirements
   function automatic void ref_model(input bit md, input int maxp,
                                     output int res, output int nrd, output int nwr,
                                     output logic [7:0] wd, output logic [7:0] dat);
      int   i;
      int   polls;
      logic prev;
      bit   lim;
      bit   fin;
      logic [7:0] d;
      nwr = 0; wd = 8'h00; dat = 8'h00; res = 0; nrd = 0;
      i = 1; polls = 0; lim = 1'b0; fin = 1'b0;
      prev = scr[0][6];
      if (md) begin
         if (scr[0][3]) begin
            res = 3; nrd = 1;
         end else begin
            nwr = 1; wd = 8'h30; nrd = 2; dat = scr[1];
            res = scr[1][3] ? 4 : 0;
         end
      end else begin
         for (int k = 0; k < 30; k++) begin
            if (!fin) begin
               d = scr[i]; i++; polls++;
               if (d[6] == prev) begin
                  dat = scr[i]; nrd = i + 1; res = 0; fin = 1'b1;
               end else begin
                  prev = d[6];
                  if (lim) begin
                     res = 1; nrd = i; nwr = 1; wd = 8'hF0; fin = 1'b1;
                  end else if (polls >= maxp) begin
                     res = 2; nrd = i; nwr = 1; wd = 8'hF0; fin = 1'b1;
                  end else if (d[5]) begin
                     lim = 1'b1;
                  end
               end
            end
         end
      end
   endfunction

   // flash responder and bus monitors
   initial begin : responder
      int   wait_n;
      int   idle;
      logic prev_act;
      logic act;
      logic prev_done;
      wait_n = 0; idle = GAP; prev_act = 1'b0; prev_done = 1'b0;
      ack = 1'b0; rdat = 8'h00;
      forever begin
         @(negedge clk);
         act = rd_req | wr_req;
         if (rd_req && wr_req) both_bad++;
         if (act && !prev_act && idle < GAP) gap_bad++;
         if (act) idle = 0; else idle++;
         prev_act = act;
         if (done && prev_done) done_wide++;
         prev_done = done;
         if (ack) begin
            ack = 1'b0;
         end else if (act) begin
            if (wait_n > 0) begin
               wait_n--;
            end else begin
               ack = 1'b1;
               if (rd_req) begin
                  rdat = scr[(rd_idx < 31) ? rd_idx : 31];
                  rd_idx++;
               end else begin
                  wr_cnt++;
                  wr_last = wr_data;
               end
               wait_n = $urandom % 3;
            end
         end
      end
   end

   task automatic fill(input logic [7:0] v);
      for (int k = 0; k < 32; k++) scr[k] = v;
   endtask

   task automatic build_random();
      logic v;
      logic [7:0] r;
      v = 1'($urandom % 2);
      for (int k = 0; k < 32; k++) begin
         r = 8'($urandom);
         r[6] = v;
         r[5] = (($urandom % 8) == 0);
         scr[k] = r;
         if (($urandom % 5) != 0) v = ~v;
      end
   endtask

   task automatic run_op(input bit md, input int maxp, input string tag, input bit poke);
      int res, nrd, nwr, n;
      logic [7:0] wd, dat;
      string t;
      ref_model(md, maxp, res, nrd, nwr, wd, dat);
      if (tag != "") t = tag;
      else if (md) t = (res == 3) ? "R7" : "R8";
      else if (res == 1) t = "R4";
      else if (res == 2) t = "R6";
      else t = "R2";
      rd_idx = 0; wr_cnt = 0; wr_last = 8'h00;
      @(negedge clk);
      start = 1'b1; mode = md; max_polls = 8'(maxp);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (6) @(negedge clk);
         start = 1'b1; mode = ~md;
         @(negedge clk);
         start = 1'b0; mode = md;
      end
      n = 0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
      check(n < 4000, t, "completion reached", n, 0);
      check(int'(result) == res, t, "result code", int'(result), res);
      check(rd_idx == nrd, t, "read count", rd_idx, nrd);
      check(wr_cnt == nwr, t, "write count", wr_cnt, nwr);
      if (nwr > 0) check(wr_last == wd, t, "command byte", int'(wr_last), int'(wd));
      if (res == 0) check(data == dat, t, "final data", int'(data), int'(dat));
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      int md;
      void'($urandom(32'd20240611));
      fill(8'h00);
      start = 1'b0; mode = 1'b0; max_polls = 8'd8;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check(!rd_req && !wr_req, "R1", "strobes in reset", int'({rd_req, wr_req}), 0);
      check(!busy && !done, "R1", "busy/done in reset", int'({busy, done}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!rd_req && !wr_req && !busy && !done, "R1", "quiet after reset",
            int'({rd_req, wr_req, busy, done}), 0);

      // R2: immediate settle, one extra read returns the data
      fill(8'h40); scr[2] = 8'h5A;
      run_op(1'b0, 5, "R2", 1'b0);
      // R4: limit bit then toggling again
      fill(8'h00); scr[1] = 8'h40; scr[2] = 8'h20; scr[3] = 8'h40;
      run_op(1'b0, 10, "R4", 1'b0);
      // R5: limit bit then settled
      fill(8'h00); scr[1] = 8'h60; scr[2] = 8'h40; scr[3] = 8'h11;
      run_op(1'b0, 10, "R5", 1'b0);
      // R6: budget used up with plain toggling
      for (int k = 0; k < 32; k++) scr[k] = (k % 2) ? 8'h40 : 8'h00;
      run_op(1'b0, 4, "R6", 1'b0);
      // R6: budget exhausted on the same read that carries bit 5
      fill(8'h00); scr[1] = 8'h40; scr[2] = 8'h20; scr[3] = 8'h40;
      run_op(1'b0, 2, "R6", 1'b0);
      // R7: window already closed
      fill(8'h08);
      run_op(1'b1, 5, "R7", 1'b0);
      // R8: accepted and possibly not accepted
      fill(8'h00); scr[1] = 8'h04;
      run_op(1'b1, 5, "R8", 1'b0);
      fill(8'h00); scr[1] = 8'h08;
      run_op(1'b1, 5, "R8", 1'b0);
      // R9: second start while busy is ignored
      for (int k = 0; k < 32; k++) scr[k] = (k % 2) ? 8'h48 : 8'h08;
      run_op(1'b0, 6, "R9", 1'b1);

      for (int it = 0; it < 40; it++) begin
         build_random();
         md = (($urandom % 3) == 0) ? 1 : 0;
         run_op(md[0], 1 + int'($urandom % 20), "", 1'b0);
      end

      check(gap_bad == 0, "R3", "strobe spacing violations", gap_bad, 0);
      check(both_bad == 0, "R10", "both strobes high", both_bad, 0);
      check(done_wide == 0, "R10", "done wider than one cycle", done_wide, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule